// File: doc/BRIEF.md
# DMA Line-Chunking Request Engine

This block takes one DMA command at a time: a direction (read or write), a start byte address, a byte length and a completion delay. It splits the command into memory requests that never span a cache-line boundary. The first piece runs from the start address up to the next line edge. Each piece after it is a whole line, and the final piece holds whatever bytes are left. The pieces go out one per cycle on a valid/accept request channel. A request that memory refuses is parked until memory raises a retry strobe, and the same request is then offered again.

The engine does not move data. It generates addresses and sizes only. It keeps an outstanding count covering every piece of the live command, and lowers that count as responses come back. Responses are assumed to return in request order. Progress toward completion is credited with the size of the piece that was requested, not with anything the response carries. When the last byte is accounted for, a one-cycle completion pulse follows after the response latency plus the command's own delay.

A drain handshake reports that no responses are outstanding. It answers at once when the count is already zero. Otherwise it answers in the first cycle the count reads zero.

Top module: `dma_chunk_engine`

## Requirements
- R1: Each request's size is the smaller of the bytes left in the command and the bytes from its address up to the next LINE_BYTES boundary. Address bits below log2(LINE_BYTES) are the offset. Successive requests carry contiguous addresses, so every request after the first starts on a line boundary.
- R2: `req_valid_o` presents the current request together with `req_write_o`, which is the command's direction. The request is taken in a cycle where `req_accept_i` is also high. If more pieces remain, the next piece is presented in the following cycle.
- R3: If a presented request is not accepted, `req_valid_o` drops from the next cycle onward. It rises again, with the same address and size, in the cycle after `retry_i` is seen high. `retry_i` has no effect at any other time.
- R4: The outstanding count rises by the command's total number of pieces, ceil((offset + length) / LINE_BYTES), in the cycle the command is taken. It falls by one for each accepted response.
- R5: Completion is armed only by the response that credits the final piece, counting responses in order against the requested piece sizes.
- R6: `done_o` is a single-cycle pulse, high exactly 1 + L + D cycles after the cycle of the final response. L is `rsp_latency_i` sampled with that response, and D is the `cmd_delay_i` captured when the command was taken.
- R7: A zero-length command issues no requests and pulses `done_o` exactly D + 1 cycles after the cycle it is taken.
- R8: A command is taken when `cmd_valid_i` is high and `busy_o` is low. `busy_o` is high from the next cycle up to and including the `done_o` cycle. Commands offered while `busy_o` is high are ignored.
- R9: `drain_req_i` raised while the outstanding count is zero makes `drain_ack_o` high in that same cycle.
- R10: `drain_req_i` raised while responses are outstanding is remembered, and `drain_ack_o` is raised in the first cycle the count is zero.
- R11: A response arriving while the outstanding count is zero raises `rsp_err_o` for one cycle, in the next cycle. It changes neither the count nor completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offer |
| cmd_write_i | input | 1 | Command direction, 1 = write |
| cmd_addr_i | input | ADDR_W | Start byte address |
| cmd_len_i | input | LEN_W | Length in bytes |
| cmd_delay_i | input | DLY_W | Extra cycles before completion |
| busy_o | output | 1 | Command in progress |
| req_valid_o | output | 1 | Request presented |
| req_write_o | output | 1 | Request direction |
| req_addr_o | output | ADDR_W | Request byte address |
| req_size_o | output | log2(LINE_BYTES)+1 | Request size in bytes |
| req_accept_i | input | 1 | Memory takes the presented request |
| retry_i | input | 1 | Memory invites a parked request again |
| rsp_valid_i | input | 1 | One response returned |
| rsp_latency_i | input | DLY_W | Latency carried with the response |
| done_o | output | 1 | Completion pulse |
| rsp_err_o | output | 1 | Response arrived with nothing outstanding |
| drain_req_i | input | 1 | Drain request |
| drain_ack_o | output | 1 | Nothing outstanding |

## Verification
Several of the engine's functions can fall in the same cycle. A response can decrement the count in a cycle where a request is rejected, accepted or re-presented after a retry. The final response can also land in the same cycle as a pending or freshly raised drain request, so the drain acknowledge and the arming of completion coincide. The bench makes these overlaps happen by randomising accept, retry, response and drain activity on every cycle across commands with unaligned, aligned, single-byte, zero and long lengths. A behavioural model, built from integers and stepped once per clock, decides every output independently, and each output is compared against it in every cycle.

// File: rtl/dma_chunk_pkg.sv
package dma_chunk_pkg;
  typedef enum logic [1:0] {
    SND_IDLE,
    SND_PRESENT,
    SND_PARKED
  } snd_state_e;
endpackage

// File: rtl/dma_chunk_walk.sv
module dma_chunk_walk #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int LINE_LG = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               adv_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [LINE_LG:0]   size_o,
  output logic               last_o
);
  localparam int LINE = 1 << LINE_LG;

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LINE_LG:0]  room;

  assign room   = (LINE_LG+1)'(LINE) - {1'b0, addr_q[LINE_LG-1:0]};
  assign size_o = (rem_q < LEN_W'(room)) ? rem_q[LINE_LG:0] : room;
  assign last_o = (rem_q == LEN_W'(size_o));
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      rem_q  <= len_i;
    end else if (adv_i) begin
      addr_q <= addr_q + ADDR_W'(size_o);
      rem_q  <= rem_q - LEN_W'(size_o);
    end
  end

  AST_NO_LINE_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> ({1'b0, addr_q[LINE_LG-1:0]} + size_o) <= (LINE_LG+1)'(LINE)); // R1
  AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> rem_q != '0); // R5
endmodule

// File: rtl/dma_send_ctrl.sv
module dma_send_ctrl
  import dma_chunk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  input  logic accept_i,
  input  logic retry_i,
  output logic valid_o,
  output logic adv_o
);
  snd_state_e state_q, state_d;

  assign valid_o = (state_q == SND_PRESENT);
  assign adv_o   = valid_o && accept_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SND_IDLE:    if (start_i) state_d = SND_PRESENT;
      SND_PRESENT: begin
        if (!accept_i)   state_d = SND_PARKED;
        else if (last_i) state_d = SND_IDLE;
      end
      SND_PARKED:  if (retry_i) state_d = SND_PRESENT;
      default:     state_d = SND_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SND_IDLE;
    else         state_q <= state_d;
  end

  AST_DROP_ON_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !accept_i |=> !valid_o); // R3
  AST_WAIT_FOR_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SND_PARKED) && !retry_i |=> !valid_o); // R3
  AST_RETRY_REPRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SND_PARKED) && retry_i |=> valid_o); // R3
endmodule

// File: rtl/dma_done_timer.sv
module dma_done_timer #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic         active_q;
  logic [W-1:0] cnt_q;

  assign done_o = active_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      cnt_q    <= val_i;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i |=> !done_o); // R6
endmodule

// File: rtl/dma_chunk_engine.sv
module dma_chunk_engine #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int DLY_W      = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cmd_valid_i,
  input  logic                          cmd_write_i,
  input  logic [ADDR_W-1:0]             cmd_addr_i,
  input  logic [LEN_W-1:0]              cmd_len_i,
  input  logic [DLY_W-1:0]              cmd_delay_i,
  output logic                          busy_o,
  output logic                          req_valid_o,
  output logic                          req_write_o,
  output logic [ADDR_W-1:0]             req_addr_o,
  output logic [$clog2(LINE_BYTES):0]   req_size_o,
  input  logic                          req_accept_i,
  input  logic                          retry_i,
  input  logic                          rsp_valid_i,
  input  logic [DLY_W-1:0]              rsp_latency_i,
  output logic                          done_o,
  output logic                          rsp_err_o,
  input  logic                          drain_req_i,
  output logic                          drain_ack_o
);
  localparam int LINE_LG = $clog2(LINE_BYTES);
  localparam int CNT_W   = LEN_W - LINE_LG + 2;
  localparam int TMR_W   = DLY_W + 1;

  logic              busy_q, write_q, err_q, pend_q;
  logic [DLY_W-1:0]  dly_q;
  logic [CNT_W-1:0]  out_cnt_q, out_cnt_d, nch;
  logic [LEN_W:0]    span;
  logic              cmd_take, len_zero, walk_load, rsp_ok, cnt_zero;
  logic              req_last, req_adv;
  logic [ADDR_W-1:0] rsp_addr;
  logic [LINE_LG:0]  rsp_size;
  logic              rsp_last, tmr_load;
  logic [TMR_W-1:0]  tmr_val;

  assign cmd_take  = cmd_valid_i && !busy_q;
  assign len_zero  = (cmd_len_i == '0);
  assign walk_load = cmd_take && !len_zero;
  assign cnt_zero  = (out_cnt_q == '0);
  assign rsp_ok    = rsp_valid_i && !cnt_zero;

  // pieces = ceil((offset + len) / line)
  assign span = {1'b0, cmd_len_i} + (LEN_W+1)'(cmd_addr_i[LINE_LG-1:0])
              + (LEN_W+1)'(LINE_BYTES - 1);
  assign nch  = CNT_W'(span >> LINE_LG);

  always_comb begin
    out_cnt_d = out_cnt_q;
    if (walk_load) out_cnt_d = out_cnt_d + nch;
    if (rsp_ok)    out_cnt_d = out_cnt_d - 1'b1;
  end

  dma_chunk_walk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_LG(LINE_LG)) u_req_walk (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(walk_load), .addr_i(cmd_addr_i),
    .len_i (cmd_len_i), .adv_i(req_adv), .addr_o(req_addr_o), .size_o(req_size_o),
    .last_o(req_last)
  );

  dma_chunk_walk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_LG(LINE_LG)) u_rsp_walk (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(walk_load), .addr_i(cmd_addr_i),
    .len_i (cmd_len_i), .adv_i(rsp_ok), .addr_o(rsp_addr), .size_o(rsp_size),
    .last_o(rsp_last)
  );

  dma_send_ctrl u_send (
    .clk_i  (clk_i), .rst_ni(rst_ni), .start_i(walk_load), .last_i(req_last),
    .accept_i(req_accept_i), .retry_i(retry_i), .valid_o(req_valid_o), .adv_o(req_adv)
  );

  assign tmr_load = (cmd_take && len_zero) || (rsp_ok && rsp_last);
  assign tmr_val  = cmd_take ? TMR_W'(cmd_delay_i)
                             : TMR_W'(rsp_latency_i) + TMR_W'(dly_q);

  dma_done_timer #(.W(TMR_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .done_o(done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      write_q   <= 1'b0;
      dly_q     <= '0;
      out_cnt_q <= '0;
      err_q     <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (cmd_take) begin
        busy_q  <= 1'b1;
        write_q <= cmd_write_i;
        dly_q   <= cmd_delay_i;
      end else if (done_o) begin
        busy_q  <= 1'b0;
      end
      out_cnt_q <= out_cnt_d;
      err_q     <= rsp_valid_i && cnt_zero;
      pend_q    <= pend_q ? !cnt_zero : (drain_req_i && !cnt_zero);
    end
  end

  assign busy_o      = busy_q;
  assign req_write_o = write_q;
  assign rsp_err_o   = err_q;
  assign drain_ack_o = (drain_req_i || pend_q) && cnt_zero;

  AST_ERR_ON_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && cnt_zero |=> rsp_err_o); // R11
  AST_CNT_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ok && !cmd_take |=> out_cnt_q == $past(out_cnt_q) - 1'b1); // R4
  AST_IDLE_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_req_i && !busy_o |-> drain_ack_o); // R9
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R8
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o); // R8
  AST_RSP_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ok && !rsp_last |=> rsp_addr[LINE_LG-1:0] == '0); // R1
  AST_RSP_CREDIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ok |-> rsp_size != '0); // R5
endmodule

// File: tb/dma_chunk_engine_tb.sv
module dma_chunk_engine_tb;
  localparam int ADDR_W = 32, LEN_W = 16, LINE = 64, DLY_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_write = 0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic [DLY_W-1:0]  cmd_delay = '0, rsp_latency = '0;
  logic req_accept = 0, retry = 0, rsp_valid = 0, drain_req = 0;
  logic busy, req_valid, req_write, done, rsp_err, drain_ack;
  logic [ADDR_W-1:0] req_addr;
  logic [6:0]        req_size;

  always #5 clk = ~clk;

  dma_chunk_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE), .DLY_W(DLY_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len), .cmd_delay_i(cmd_delay), .busy_o(busy),
    .req_valid_o(req_valid), .req_write_o(req_write), .req_addr_o(req_addr),
    .req_size_o(req_size), .req_accept_i(req_accept), .retry_i(retry),
    .rsp_valid_i(rsp_valid), .rsp_latency_i(rsp_latency), .done_o(done),
    .rsp_err_o(rsp_err), .drain_req_i(drain_req), .drain_ack_o(drain_ack)
  );

  int checks = 0, errors = 0, cyc = 0;
  // reference model state
  int m_st = 0, m_addr = 0, m_rem = 0, m_raddr = 0, m_rrem = 0;
  int m_cnt = 0, m_timer = -1, m_dly = 0, m_infl = 0;
  bit m_busy = 0, m_err = 0, m_pend = 0, m_write = 0;
  int done_cyc = -1;
  bit seen_req = 0;

  function automatic int csize(int a, int r);
    int room = LINE - (a % LINE);
    return (r < room) ? r : room;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic compare();
    chk("R2 R3 req_valid", req_valid, m_st == 1);
    if (m_st == 1) begin
      chk("R1 req_addr", req_addr, m_addr);
      chk("R1 req_size", req_size, csize(m_addr, m_rem));
      chk("R2 req_write", req_write, m_write);
    end
    chk("R8 busy", busy, m_busy);
    chk("R5 R6 done", done, m_timer == 0);
    chk("R4 R9 R10 drain_ack", drain_ack, (drain_req || m_pend) && m_cnt == 0);
    chk("R11 rsp_err", rsp_err, m_err);
  endtask

  task automatic model_step();
    int sz = csize(m_addr, m_rem);
    int rsz = csize(m_raddr, m_rrem);
    bit take = cmd_valid && !m_busy;
    bit rok = rsp_valid && (m_cnt != 0);
    bit done_now = (m_timer == 0);
    bit cz = (m_cnt == 0);
    m_err  = rsp_valid && cz;
    m_pend = m_pend ? !cz : (drain_req && !cz);
    if (m_timer >= 0) m_timer--;
    if (rok) begin
      m_cnt--; m_infl--;
      if (rsz == m_rrem) m_timer = int'(rsp_latency) + m_dly;
      m_raddr += rsz; m_rrem -= rsz;
    end
    if (m_st == 1) begin
      if (req_accept) begin
        m_infl++; m_addr += sz; m_rem -= sz;
        m_st = (m_rem == 0) ? 0 : 1;
      end else m_st = 2;
    end else if (m_st == 2 && retry) m_st = 1;
    if (take) begin
      m_busy = 1; m_dly = int'(cmd_delay); m_write = cmd_write;
      if (cmd_len == 0) m_timer = int'(cmd_delay);
      else begin
        m_addr = int'(cmd_addr); m_rem = int'(cmd_len);
        m_raddr = m_addr; m_rrem = m_rem; m_st = 1;
        m_cnt += (m_addr % LINE + m_rem + LINE - 1) / LINE;
      end
    end else if (done_now) m_busy = 0;
  endtask

  task automatic cycle();
    #2;
    compare();
    if (done) done_cyc = cyc;
    if (req_valid) seen_req = 1;
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic rand_mem();
    req_accept  = ($urandom % 4) != 0;
    retry       = ($urandom % 5) == 0;
    rsp_valid   = (m_infl > 0) && ($urandom % 2 == 1);
    rsp_latency = DLY_W'($urandom % 4);
    drain_req   = ($urandom % 12) == 0;
  endtask

  task automatic quiet();
    cmd_valid = 0; req_accept = 0; retry = 0; rsp_valid = 0; drain_req = 0;
  endtask

  task automatic run(int a, int l, int d, bit w);
    int start;
    rand_mem();
    cmd_valid = 1; cmd_addr = ADDR_W'(a); cmd_len = LEN_W'(l);
    cmd_delay = DLY_W'(d); cmd_write = w;
    start = cyc; seen_req = 0; done_cyc = -1;
    cycle();
    while (m_busy) begin
      rand_mem();
      // offers while busy must be ignored (R8)
      cmd_valid = ($urandom % 8) == 0;
      cmd_addr  = ADDR_W'($urandom % 4096);
      cmd_len   = LEN_W'($urandom % 300);
      cycle();
    end
    quiet();
    cycle();
    if (l == 0) begin
      chk("R7 zero-length done cycle", done_cyc, start + 1 + d);
      chk("R7 zero-length issues no request", seen_req, 0);
    end else begin
      chk("R5 completion seen", done_cyc > start, 1);
      chk("R4 drained after command", drain_ack || m_cnt == 0, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R8 reset busy", busy, 0);
    chk("R2 reset req_valid", req_valid, 0);
    chk("R6 reset done", done, 0);
    chk("R11 reset rsp_err", rsp_err, 0);
    cycle();
    // stray response while idle
    rsp_valid = 1; cycle(); rsp_valid = 0;
    chk("R11 err flagged", rsp_err, 1);
    cycle();
    // drain while idle
    drain_req = 1; #1 chk("R9 immediate drain ack", drain_ack, 1);
    cycle(); drain_req = 0; cycle();
    run('h0, 128, 2, 1);
    run('h3C, 10, 0, 0);
    run('h10, 200, 5, 1);
    run('h7F, 1, 1, 0);
    run('h40, 0, 3, 0);
    run('h41, 0, 0, 1);
    run('h1234, 1000, 7, 1);
    run('h3F, 64, 15, 0);
    for (int i = 0; i < 40; i++)
      run(int'($urandom % 8192), int'($urandom % 600), int'($urandom % 16), 1'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0 cycle=%0d", 1, cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule